// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block converts one binary-coded decimal digit into the seven active-high drive levels of a single seven-segment display. An input register sits in front of the decoder. While the hold control is low, the register samples the digit on every clock, and a bypass path sends the live digit straight to the decoder. The segments therefore track the inputs within the same cycle. While hold is high, the decoder reads the register instead, and the display stays frozen on the last digit that was sampled.

Two active-low overrides act on the outputs after the decoder. Lamp test lights every segment, so the display itself can be checked. Blanking darkens every segment. Lamp test wins over blanking, and blanking wins over the digit. Neither override touches the stored digit. Codes above nine decode to a dark display.

Top module: `segLatchDecoder`

## Requirements
- R1: digitIn[0] is the least significant bit. While holdEn is low and both overrides are inactive (high), segOut shows the decode of the live digitIn in the same cycle, with no clock delay.
- R2: segOut bit 0 drives segment a, and bits 1 to 6 drive b to g, all active high. Digits 0 to 9 give 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F. So six includes the top bar a, and nine includes the bottom bar d.
- R3: Codes 10 to 15 give segOut = 0x00.
- R4: While holdEn is high, segOut shows the decode of the digit sampled at the last rising clock edge at which holdEn was low. Changes on digitIn while holdEn is high have no effect on segOut.
- R5: blankN low with lampTestN high forces segOut to 0x00, whatever the digit and holdEn.
- R6: lampTestN low forces segOut to 0x7F, whatever blankN, the digit and holdEn.
- R7: The overrides never change the stored digit. When both overrides are released while hold is still high, the display shows the digit held before the overrides were applied.
- R8: rst, sampled high at a rising clock edge, clears the stored digit to zero. With holdEn high after reset, the display shows 0x3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| digitIn | input | 4 | BCD digit, bit 0 least significant |
| holdEn | input | 1 | High: display the stored digit; low: sample and pass the live digit through |
| blankN | input | 1 | Active-low blanking |
| lampTestN | input | 1 | Active-low lamp test |
| segOut | output | 7 | Segment drives, bit 0 = a through bit 6 = g, active high |

## Verification
On every cycle, the assertions check the following at the ports:
- the lamp-test pattern and its priority over blanking;
- the dark display under blanking;
- the dark display for out-of-range live codes;
- a stable display across consecutive held cycles.

Only the bench scenarios can show four further behaviours:
- the exact pattern of each digit;
- which clock edge captures the digit when hold rises;
- the return of the original digit after the overrides are lifted (R7);
- the reset value seen through a hold.

// File: rtl/segPkg.sv
package segPkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_N   = 7;
  localparam int MAX_DIGIT = 9;

  typedef struct packed {
    logic captureEn;  // sample the live digit this cycle
    logic useStored;  // decoder reads the register instead of the bypass
    logic forceAll;   // light every segment
    logic forceOff;   // darken every segment
  } segStrobes_t;
endpackage

// File: rtl/segControl.sv
module segControl
  import segPkg::*;
(
  input  logic        holdEn,
  input  logic        blankN,
  input  logic        lampTestN,
  output segStrobes_t strobes
);
  always_comb begin
    strobes.captureEn = ~holdEn;
    strobes.useStored = holdEn;
    strobes.forceAll  = ~lampTestN;
    strobes.forceOff  = lampTestN & ~blankN;
  end
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segPkg::*;
#(
  parameter int DW = DIGIT_W,
  parameter int SN = SEG_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] digitIn,
  input  segStrobes_t   strobes,
  output logic [SN-1:0] segOut
);
  logic [DW-1:0] storedDigit;
  logic [DW-1:0] shownDigit;
  logic [SN-1:0] decoded;

  always_ff @(posedge clk) begin
    if (rst)                    storedDigit <= '0;
    else if (strobes.captureEn) storedDigit <= digitIn;
  end

  assign shownDigit = strobes.useStored ? storedDigit : digitIn;

  always_comb begin
    decoded = '0;
    if (int'(shownDigit) <= MAX_DIGIT) begin
      case (int'(shownDigit))
        0: decoded = SN'(7'h3F);
        1: decoded = SN'(7'h06);
        2: decoded = SN'(7'h5B);
        3: decoded = SN'(7'h4F);
        4: decoded = SN'(7'h66);
        5: decoded = SN'(7'h6D);
        6: decoded = SN'(7'h7D);
        7: decoded = SN'(7'h07);
        8: decoded = SN'(7'h7F);
        default: decoded = SN'(7'h6F);
      endcase
    end
  end

  for (genvar s = 0; s < SN; s++) begin : g_segDrive
    assign segOut[s] = strobes.forceAll | (~strobes.forceOff & decoded[s]);
  end
endmodule

// File: rtl/segLatchDecoder.sv
module segLatchDecoder
  import segPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] digitIn,
  input  logic               holdEn,
  input  logic               blankN,
  input  logic               lampTestN,
  output logic [SEG_N-1:0]   segOut
);
  segStrobes_t strobes;

  segControl u_ctrl (
    .holdEn(holdEn), .blankN(blankN), .lampTestN(lampTestN), .strobes(strobes)
  );

  segDatapath #(.DW(DIGIT_W), .SN(SEG_N)) u_dp (
    .clk(clk), .rst(rst), .digitIn(digitIn), .strobes(strobes), .segOut(segOut)
  );
endmodule

// File: rtl/segLatchDecoder_checker.sv
module segLatchDecoder_checker
  import segPkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [DIGIT_W-1:0] digitIn,
  input logic               holdEn,
  input logic               blankN,
  input logic               lampTestN,
  input logic [SEG_N-1:0]   segOut
);
  assert_lamp_all_on_R6: assert property (@(posedge clk) disable iff (rst)
    !lampTestN |-> segOut == 7'h7F);

  assert_blank_dark_R5: assert property (@(posedge clk) disable iff (rst)
    (lampTestN && !blankN) |-> segOut == 7'h00);

  assert_out_of_range_dark_R3: assert property (@(posedge clk) disable iff (rst)
    (lampTestN && blankN && !holdEn && digitIn > 4'd9) |-> segOut == 7'h00);

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (holdEn && lampTestN && blankN && $past(holdEn) && $past(lampTestN)
     && $past(blankN) && !$past(rst)) |-> $stable(segOut));
endmodule

bind segLatchDecoder segLatchDecoder_checker u_chk (
  .clk(clk), .rst(rst), .digitIn(digitIn), .holdEn(holdEn),
  .blankN(blankN), .lampTestN(lampTestN), .segOut(segOut)
);

// File: tb/segLatchDecoder_test.sv
module segLatchDecoder_test;
  logic       clk = 0;
  logic       rst = 1;
  logic [3:0] digitIn = 0;
  logic       holdEn = 1;
  logic       blankN = 1;
  logic       lampTestN = 1;
  logic [6:0] segOut;

  int checks = 0;
  int errors = 0;
  int modelStored = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  segLatchDecoder uut (
    .clk(clk), .rst(rst), .digitIn(digitIn), .holdEn(holdEn),
    .blankN(blankN), .lampTestN(lampTestN), .segOut(segOut)
  );

  // reference model of the stored digit
  always @(posedge clk) begin
    if (rst) modelStored = 0;
    else if (!holdEn) modelStored = int'(digitIn);
  end

  function automatic int pattern(int v);
    case (v)
      0: return 'h3F; 1: return 'h06; 2: return 'h5B; 3: return 'h4F;
      4: return 'h66; 5: return 'h6D; 6: return 'h7D; 7: return 'h07;
      8: return 'h7F; 9: return 'h6F;
      default: return 0;
    endcase
  endfunction

  function automatic int expected();
    if (!lampTestN) return 'h7F;
    if (!blankN) return 0;
    return pattern(holdEn ? modelStored : int'(digitIn));
  endfunction

  function automatic string autoTag();
    if (!lampTestN) return "R6";
    if (!blankN) return "R5";
    if (holdEn) return "R4";
    if (digitIn > 9) return "R3";
    return "R1_R2";
  endfunction

  // drive at negedge, compare 3 ns later (before next rising edge)
  task automatic step(input logic [3:0] d, input logic h, input logic b,
                      input logic l, input string tag);
    @(negedge clk);
    digitIn = d; holdEn = h; blankN = b; lampTestN = l;
    #3;
    checks++;
    if (int'(segOut) != expected()) begin
      errors++;
      $display("FAIL %s: segOut actual %02h expected %02h (d=%0d h=%0b b=%0b l=%0b)",
               (tag == "") ? autoTag() : tag, segOut, expected(), d, h, b, l);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset with hold high: stored digit must read back as zero (R8)
    step(4'd7, 1, 1, 1, "R8");
    step(4'd3, 1, 1, 1, "R8");
    @(negedge clk); rst = 0;
    step(4'd9, 1, 1, 1, "R8");
    step(4'd2, 1, 1, 1, "R8");

    // transparent sweep of every code (R1, R2, R3)
    for (int v = 0; v < 16; v++) step(4'(v), 0, 1, 1, "");

    // capture 5 then hold while inputs sweep (R4)
    step(4'd5, 0, 1, 1, "R1");
    for (int v = 0; v < 16; v++) step(4'(v), 1, 1, 1, "R4");

    // overrides during hold, then release (R5, R6, R7)
    step(4'd8, 1, 1, 0, "R6");
    step(4'd1, 1, 0, 1, "R5");
    step(4'd0, 1, 0, 0, "R6");
    step(4'd3, 1, 1, 1, "R7");

    // overrides while transparent still capture the digit (R7)
    step(4'd6, 0, 0, 0, "R6");
    step(4'd2, 1, 1, 1, "R7");
    step(4'd4, 0, 0, 1, "R5");
    step(4'd9, 1, 1, 1, "R7");

    // full combination sweep against the model
    for (int h = 0; h < 2; h++)
      for (int b = 0; b < 2; b++)
        for (int l = 0; l < 2; l++)
          for (int v = 0; v < 16; v++)
            step(4'(v), 1'(h), 1'(b), 1'(l), "");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule